// File: doc/BRIEF.md
# Banked GPIO controller with edge/level interrupts and wake

This block is a memory-mapped general-purpose I/O controller. Pins come in banks of 32, and each register group has one 32-bit word per bank: pin n sits in the word at group offset + 4*(n/32), at bit n%32. Software picks the direction of each pin and drives outputs only through a write-1-to-set port and a write-1-to-clear port. It reads the synchronized input level of every pin from a read-only word.

Every input first passes a two-flop synchronizer. It then goes through a glitch filter, which can be bypassed per pin. The conditioned value feeds a per-pin detector. In edge mode, rising and falling edges can be armed separately or together. In level mode, the active level can be high or low. A detected event sets a sticky interrupt status bit and a sticky wake status bit. Both are cleared by writing 1. A mask word gates interrupt status onto one combined interrupt line, and a separate wake mask gates wake status onto the wake line.

The register port is a simple synchronous bus. A write takes effect at the clock edge where it is presented. Read data is registered and appears one clock after the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and pin_out, pin_oe, irq_out and wake_out are all 0.
- R2: A write to the set port (0x034 + 4*bank) sets each pin_out bit whose data bit is 1. A write to the clear port (0x04c + 4*bank) clears each such bit. Data bits of 0 leave pin_out unchanged, and both ports read as 0.
- R3: The direction word (0x01c + 4*bank) is readable and writable. A bit of 1 drives the matching pin_oe bit high (output); a bit of 0 makes the pin an input.
- R4: The level word (0x004 + 4*bank) returns pin_in after a two-flop synchronizer. Writes to it are ignored.
- R5: With its bypass bit (0x094 + 4*bank) at 0, a pin's input must hold a new value for 3 consecutive clocks before the detector sees it, so a 2-clock pulse is dropped. With the bypass bit at 1, the synchronized value passes straight through.
- R6: With the type bit (0x300 + 4*bank) at 0, a pin is edge-detected. The rising-enable bit (0x064 + 4*bank) arms rising edges, and the falling-enable bit (0x07c + 4*bank) arms falling edges, independently or both.
- R7: With the type bit at 1, a pin is level-detected. The polarity bit (0x318 + 4*bank) set to 1 means active-low and 0 means active-high. The status is set again on every clock while the level is active, so a clear takes effect only after the level has gone away.
- R8: The interrupt status word (0x0c4 + 4*bank) is sticky. Writing 1 clears a bit, writing 0 leaves it unchanged, and a new event in the same clock wins over the clear.
- R9: irq_out is the OR over all pins of status AND mask, with the mask at 0x0ac + 4*bank and 1 meaning enabled. It is registered one clock after the status.
- R10: The wake status word (0x418 + 4*bank) is set by the same events as the interrupt status and is cleared separately by writing 1. wake_out is the registered OR of wake status AND wake mask (0x400 + 4*bank).
- R11: Each group's words are decoded per bank, so a write to one bank does not touch another. The configuration word at 0x000 and unmapped addresses read as 0.
- R12: bus_rdata is registered and shows the word addressed in the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for last cycle's address |
| pin_in | input | NBANKS*32 | Asynchronous pin inputs |
| pin_out | output | NBANKS*32 | Output drive values |
| pin_oe | output | NBANKS*32 | Output enables (direction) |
| irq_out | output | 1 | Combined masked interrupt |
| wake_out | output | 1 | Combined masked wake request |

## Verification
The assertions check four things on every cycle. A status bit never drops without a clear written the cycle before. A cleared bit with no competing event is 0 the next cycle. pin_out and pin_oe hold while no write is presented. The filtered value only steps to a level the synchronizer has held steadily, unless the pin is bypassed. An all-zero mask also keeps the combined lines low. Some behaviours can only be shown by the bench's scenarios: which polarity and edge settings actually fire, that a 2-clock glitch is dropped while a longer pulse gets through, that a level interrupt cannot be cleared while the level is active, and that bank words are decoded independently.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFF_LEVEL = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 12'h01c;
  localparam logic [ADDR_W-1:0] OFF_SET   = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h04c;
  localparam logic [ADDR_W-1:0] OFF_RISE  = 12'h064;
  localparam logic [ADDR_W-1:0] OFF_FALL  = 12'h07c;
  localparam logic [ADDR_W-1:0] OFF_BYP   = 12'h094;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h0ac;
  localparam logic [ADDR_W-1:0] OFF_STS   = 12'h0c4;
  localparam logic [ADDR_W-1:0] OFF_TYPE  = 12'h300;
  localparam logic [ADDR_W-1:0] OFF_POL   = 12'h318;
  localparam logic [ADDR_W-1:0] OFF_WMASK = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_WSTS  = 12'h418;

  // Byte address of the word holding bank b of a register group
  function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base, int b);
    return base + ADDR_W'(4 * b);
  endfunction
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic bypass_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (bypass_i) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else if (s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sync_o = s2_q;
  assign filt_o = filt_q;

  // R5
  filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(s2_q)));
  // R5
  filt_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(bypass_i) && (filt_q != $past(filt_q)) && !$past(rst, 2)) |-> ($past(s2_q, 2) == $past(s2_q)));
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] filt_i,
  input  logic [W-1:0] lvl_mode_i,
  input  logic [W-1:0] act_low_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] sts_clr_i,
  input  logic [W-1:0] wsts_clr_i,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] wsts_o
);
  logic [W-1:0] prev_q, sts_q, wsts_q;
  logic [W-1:0] edge_evt, lvl_evt, evt;

  always_comb begin
    edge_evt = (rise_en_i & filt_i & ~prev_q) | (fall_en_i & ~filt_i & prev_q);
    lvl_evt  = filt_i ^ act_low_i;
    evt      = (lvl_mode_i & lvl_evt) | (~lvl_mode_i & edge_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      sts_q  <= '0;
      wsts_q <= '0;
    end else begin
      prev_q <= filt_i;
      sts_q  <= (sts_q & ~sts_clr_i) | evt;
      wsts_q <= (wsts_q & ~wsts_clr_i) | evt;
    end
  end

  assign sts_o  = sts_q;
  assign wsts_o = wsts_q;

  // R8
  sts_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~sts_q & $past(sts_q) & ~$past(sts_clr_i)) == '0));
  // R8
  sts_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((sts_q & $past(sts_clr_i) & ~$past(evt)) == '0));
  // R10
  wsts_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~wsts_q & $past(wsts_q) & ~$past(wsts_clr_i)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NBANKS   = 2,
  parameter int FILT_LEN = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  input  logic [NBANKS*WORD_W-1:0] pin_in,
  output logic [NBANKS*WORD_W-1:0] pin_out,
  output logic [NBANKS*WORD_W-1:0] pin_oe,
  output logic                     irq_out,
  output logic                     wake_out
);
  localparam int NPINS = NBANKS * WORD_W;

  logic [NPINS-1:0] dir_q, out_q, rise_q, fall_q, byp_q;
  logic [NPINS-1:0] mask_q, type_q, pol_q, wmask_q;
  logic [NPINS-1:0] sync_v, filt_v, sts_v, wsts_v, sts_clr, wsts_clr;
  logic [WORD_W-1:0] rd_mux, rdata_q;
  logic irq_q, wake_q;

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      gpio_in_cond #(.FILT_LEN(FILT_LEN)) u_cond (
        .clk(clk), .rst(rst), .pin_i(pin_in[p]), .bypass_i(byp_q[p]),
        .sync_o(sync_v[p]), .filt_o(filt_v[p]));
    end
  endgenerate

  gpio_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst(rst), .filt_i(filt_v), .lvl_mode_i(type_q), .act_low_i(pol_q),
    .rise_en_i(rise_q), .fall_en_i(fall_q), .sts_clr_i(sts_clr), .wsts_clr_i(wsts_clr),
    .sts_o(sts_v), .wsts_o(wsts_v));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0; out_q <= '0; rise_q <= '0; fall_q <= '0; byp_q <= '0;
      mask_q <= '0; type_q <= '0; pol_q <= '0; wmask_q <= '0;
    end else if (bus_wr) begin
      for (int b = 0; b < NBANKS; b++) begin
        if (bus_addr == word_addr(OFF_DIR, b))   dir_q[b*WORD_W +: WORD_W]   <= bus_wdata;
        if (bus_addr == word_addr(OFF_RISE, b))  rise_q[b*WORD_W +: WORD_W]  <= bus_wdata;
        if (bus_addr == word_addr(OFF_FALL, b))  fall_q[b*WORD_W +: WORD_W]  <= bus_wdata;
        if (bus_addr == word_addr(OFF_BYP, b))   byp_q[b*WORD_W +: WORD_W]   <= bus_wdata;
        if (bus_addr == word_addr(OFF_MASK, b))  mask_q[b*WORD_W +: WORD_W]  <= bus_wdata;
        if (bus_addr == word_addr(OFF_TYPE, b))  type_q[b*WORD_W +: WORD_W]  <= bus_wdata;
        if (bus_addr == word_addr(OFF_POL, b))   pol_q[b*WORD_W +: WORD_W]   <= bus_wdata;
        if (bus_addr == word_addr(OFF_WMASK, b)) wmask_q[b*WORD_W +: WORD_W] <= bus_wdata;
        if (bus_addr == word_addr(OFF_SET, b))
          out_q[b*WORD_W +: WORD_W] <= out_q[b*WORD_W +: WORD_W] | bus_wdata;
        if (bus_addr == word_addr(OFF_CLR, b))
          out_q[b*WORD_W +: WORD_W] <= out_q[b*WORD_W +: WORD_W] & ~bus_wdata;
      end
    end
  end

  always_comb begin
    sts_clr  = '0;
    wsts_clr = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (bus_wr && bus_addr == word_addr(OFF_STS, b))  sts_clr[b*WORD_W +: WORD_W]  = bus_wdata;
      if (bus_wr && bus_addr == word_addr(OFF_WSTS, b)) wsts_clr[b*WORD_W +: WORD_W] = bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (bus_addr == word_addr(OFF_LEVEL, b)) rd_mux = rd_mux | sync_v[b*WORD_W +: WORD_W];
      if (bus_addr == word_addr(OFF_DIR, b))   rd_mux = rd_mux | dir_q[b*WORD_W +: WORD_W];
      if (bus_addr == word_addr(OFF_RISE, b))  rd_mux = rd_mux | rise_q[b*WORD_W +: WORD_W];
      if (bus_addr == word_addr(OFF_FALL, b))  rd_mux = rd_mux | fall_q[b*WORD_W +: WORD_W];
      if (bus_addr == word_addr(OFF_BYP, b))   rd_mux = rd_mux | byp_q[b*WORD_W +: WORD_W];
      if (bus_addr == word_addr(OFF_MASK, b))  rd_mux = rd_mux | mask_q[b*WORD_W +: WORD_W];
      if (bus_addr == word_addr(OFF_STS, b))   rd_mux = rd_mux | sts_v[b*WORD_W +: WORD_W];
      if (bus_addr == word_addr(OFF_TYPE, b))  rd_mux = rd_mux | type_q[b*WORD_W +: WORD_W];
      if (bus_addr == word_addr(OFF_POL, b))   rd_mux = rd_mux | pol_q[b*WORD_W +: WORD_W];
      if (bus_addr == word_addr(OFF_WMASK, b)) rd_mux = rd_mux | wmask_q[b*WORD_W +: WORD_W];
      if (bus_addr == word_addr(OFF_WSTS, b))  rd_mux = rd_mux | wsts_v[b*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      rdata_q <= rd_mux;
      irq_q   <= |(sts_v & mask_q);
      wake_q  <= |(wsts_v & wmask_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign irq_out   = irq_q;
  assign wake_out  = wake_q;

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_wr)) |-> $stable(pin_out));
  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_wr)) |-> $stable(pin_oe));
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask_q) == '0) |-> !irq_out);
  // R10
  wake_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wmask_q) == '0) |-> !wake_out);
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq_out, wake_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NBANKS(NB), .FILT_LEN(3)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_out(irq_out), .wake_out(wake_out));

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  // R3 R11 R12: register readback and bank decode
  localparam vec_t VECS [14] = '{
    '{1'b1, 12'h01c, 32'hA5A5_0F0F, 32'h0},
    '{1'b0, 12'h01c, 32'h0, 32'hA5A5_0F0F},
    '{1'b1, 12'h020, 32'h1234_5678, 32'h0},
    '{1'b0, 12'h020, 32'h0, 32'h1234_5678},
    '{1'b0, 12'h01c, 32'h0, 32'hA5A5_0F0F},
    '{1'b1, 12'h068, 32'hFFFF_0000, 32'h0},
    '{1'b0, 12'h068, 32'h0, 32'hFFFF_0000},
    '{1'b1, 12'h318, 32'h8000_0001, 32'h0},
    '{1'b0, 12'h318, 32'h0, 32'h8000_0001},
    '{1'b1, 12'h404, 32'h0000_00C3, 32'h0},
    '{1'b0, 12'h404, 32'h0, 32'h0000_00C3},
    '{1'b0, 12'h000, 32'h0, 32'h0},
    '{1'b0, 12'h034, 32'h0, 32'h0},
    '{1'b0, 12'h304, 32'h0, 32'h0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    rv = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;

    foreach (VECS[i]) begin
      if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
      else begin
        rd(VECS[i].a);
        chk(rv == VECS[i].exp, "R11 table read", 64'(rv), 64'(VECS[i].exp));
      end
    end
    // R3 direction drives pin_oe
    chk(pin_oe == {32'h1234_5678, 32'hA5A5_0F0F}, "R3 pin_oe", pin_oe, {32'h1234_5678, 32'hA5A5_0F0F});

    do_reset();
    // R1 reset state
    rd(12'h01c);
    chk(rv == 0, "R1 dir after reset", 64'(rv), 0);
    rd(12'h318);
    chk(rv == 0, "R1 pol after reset", 64'(rv), 0);
    chk({pin_out, pin_oe} == '0 && !irq_out && !wake_out, "R1 outputs", {pin_out ^ pin_oe}, 0);

    // R2 set/clear ports
    wr(12'h034, 32'h0000_00F0);
    chk(pin_out[31:0] == 32'hF0, "R2 set", 64'(pin_out[31:0]), 64'hF0);
    wr(12'h034, 32'h0000_000F);
    wr(12'h04c, 32'h0000_0030);
    chk(pin_out[31:0] == 32'hCF, "R2 clear", 64'(pin_out[31:0]), 64'hCF);
    wr(12'h034, 32'h0);
    wr(12'h04c, 32'h0);
    chk(pin_out[31:0] == 32'hCF, "R2 zero no effect", 64'(pin_out[31:0]), 64'hCF);
    wr(12'h038, 32'h1);
    chk(pin_out == {32'h1, 32'hCF}, "R2 bank1 set", pin_out, {32'h1, 32'hCF});

    // R4 level readback
    pin_in = {32'hDEAD_BEEF, 32'h1357_9BDF};
    cyc(3);
    rd(12'h004);
    chk(rv == 32'h1357_9BDF, "R4 level bank0", 64'(rv), 64'h1357_9BDF);
    rd(12'h008);
    chk(rv == 32'hDEAD_BEEF, "R4 level bank1", 64'(rv), 64'hDEAD_BEEF);
    wr(12'h004, 32'h0);
    rd(12'h004);
    chk(rv == 32'h1357_9BDF, "R4 level write ignored", 64'(rv), 64'h1357_9BDF);
    pin_in = '0;
    cyc(8);

    // R6 rising edge, R9 irq, R10 wake
    wr(12'h094, 32'h1);
    wr(12'h064, 32'h3);
    wr(12'h0ac, 32'h1);
    wr(12'h400, 32'h1);
    pin_in[0] = 1'b1;
    cyc(6);
    rd(12'h0c4);
    chk(rv[1:0] == 2'b01, "R6 rising sets status", 64'(rv[1:0]), 1);
    chk(irq_out == 1'b1, "R9 irq high", 64'(irq_out), 1);
    chk(wake_out == 1'b1, "R10 wake high", 64'(wake_out), 1);
    rd(12'h418);
    chk(rv[0] == 1'b1, "R10 wake status", 64'(rv[0]), 1);
    // R8 write 0 no effect, write 1 clears
    wr(12'h0c4, 32'h0);
    rd(12'h0c4);
    chk(rv[0] == 1'b1, "R8 zero write keeps", 64'(rv[0]), 1);
    wr(12'h0c4, 32'h1);
    cyc(2);
    rd(12'h0c4);
    chk(rv[0] == 1'b0, "R8 clear", 64'(rv[0]), 0);
    chk(irq_out == 1'b0, "R9 irq low after clear", 64'(irq_out), 0);
    chk(wake_out == 1'b1, "R10 wake independent", 64'(wake_out), 1);
    wr(12'h418, 32'h1);
    cyc(2);
    chk(wake_out == 1'b0, "R10 wake cleared", 64'(wake_out), 0);

    // R6 falling not armed
    pin_in[0] = 1'b0;
    cyc(6);
    rd(12'h0c4);
    chk(rv[0] == 1'b0, "R6 falling unarmed", 64'(rv[0]), 0);
    // R6 both edges
    wr(12'h07c, 32'h1);
    pin_in[0] = 1'b1;
    cyc(6);
    wr(12'h0c4, 32'h1);
    cyc(2);
    rd(12'h0c4);
    chk(rv[0] == 1'b0, "R6 cleared after rise", 64'(rv[0]), 0);
    pin_in[0] = 1'b0;
    cyc(6);
    rd(12'h0c4);
    chk(rv[0] == 1'b1, "R6 falling armed", 64'(rv[0]), 1);
    wr(12'h0c4, 32'hFFFF_FFFF);

    // R5 glitch filter on pin 1 (bypass 0)
    @(negedge clk); pin_in[1] = 1'b1;
    cyc(2);
    pin_in[1] = 1'b0;
    cyc(8);
    rd(12'h0c4);
    chk(rv[1] == 1'b0, "R5 2-clock glitch dropped", 64'(rv[1]), 0);
    @(negedge clk); pin_in[1] = 1'b1;
    cyc(4);
    pin_in[1] = 1'b0;
    cyc(8);
    rd(12'h0c4);
    chk(rv[1] == 1'b1, "R5 long pulse passes", 64'(rv[1]), 1);
    chk(irq_out == 1'b0, "R9 masked pin no irq", 64'(irq_out), 0);
    wr(12'h0c4, 32'hFFFF_FFFF);

    // R7 level mode: pin2 active-high, pin3 active-low
    wr(12'h094, 32'h0000_000D);
    wr(12'h318, 32'h0000_0008);
    wr(12'h300, 32'h0000_000C);
    cyc(4);
    rd(12'h0c4);
    chk((rv & 32'hC) == 32'h8, "R7 active-low fires", 64'(rv & 32'hC), 8);
    wr(12'h0c4, 32'h8);
    cyc(2);
    rd(12'h0c4);
    chk(rv[3] == 1'b1, "R7 clear blocked while active", 64'(rv[3]), 1);
    pin_in[2] = 1'b1;
    cyc(6);
    rd(12'h0c4);
    chk((rv & 32'hC) == 32'hC, "R7 active-high fires", 64'(rv & 32'hC), 12);
    pin_in[2] = 1'b0;
    pin_in[3] = 1'b1;
    cyc(6);
    wr(12'h0c4, 32'hC);
    cyc(2);
    rd(12'h0c4);
    chk((rv & 32'hC) == 32'h0, "R7 clear after inactive", 64'(rv & 32'hC), 0);

    // R11 bank1 pin 40
    wr(12'h098, 32'h100);
    wr(12'h068, 32'h100);
    wr(12'h0b0, 32'h100);
    pin_in[40] = 1'b1;
    cyc(6);
    rd(12'h0c8);
    chk(rv == 32'h100, "R11 bank1 status", 64'(rv), 64'h100);
    chk(irq_out == 1'b1, "R9 bank1 irq", 64'(irq_out), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule